// File: doc/BRIEF.md
# ADD/MUL Execution Unit with Zero-Operand Early Completion

This block is one execution unit in an out-of-order core. A scheduler dispatches one operation at a time (an ADD or a MUL), with its two operands and a destination tag. The unit computes for a fixed number of cycles, then raises a request for the shared result bus. It keeps the result and tag until the bus grants it.

The MUL latency depends on the operand values. When either operand is zero and the early-completion input is set, a MUL finishes on the short path. When that input is clear, every MUL takes the full latency. This gives a reference unit with fixed timing, which can run beside the full-featured one for timing comparison.

A parameter removes the multiplier to build an ADD-only unit. In that variant, dispatching a MUL is refused and flagged as an error.

Top module: `fu_addmul`

## Requirements
- R1: After reset, `busy`, `bus_req` and `op_err` are low.
- R2: An ADD (`issue_op` = 0) that is accepted at a clock edge raises `bus_req` exactly 6 cycles later. `bus_res` is then (a + b) modulo 2^WIDTH and `bus_tag` is the dispatched tag.
- R3: A MUL (`issue_op` = 1) with both operands nonzero raises `bus_req` 14 cycles after acceptance. `bus_res` is the low WIDTH bits of a * b.
- R4: With `early_en` = 1 at acceptance, a MUL that has a zero operand raises `bus_req` 5 cycles after acceptance, and `bus_res` is 0.
- R5: With `early_en` = 0 at acceptance, every MUL takes 14 cycles, including one with a zero operand, and a zero-operand product is still 0.
- R6: `busy` is high from the cycle after acceptance until the grant. A dispatch made while `busy` is high is ignored and does not change the result or tag that is later delivered.
- R7: While `bus_req` is high and `bus_gnt` is low, `bus_req`, `bus_res` and `bus_tag` hold their values.
- R8: When `bus_gnt` is high with `bus_req` at a clock edge, `busy` and `bus_req` are low in the next cycle, and a new dispatch can be accepted.
- R9: In the ADD-only variant (HAS_MUL = 0), a MUL dispatch is not accepted. `busy` stays low, and `op_err` is high for exactly the one cycle after the dispatch edge. ADDs still complete as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| early_en | input | 1 | Enables short MUL path for zero operands |
| issue_vld | input | 1 | Dispatch strobe |
| issue_op | input | 1 | 0 = ADD, 1 = MUL |
| issue_a | input | WIDTH | First operand |
| issue_b | input | WIDTH | Second operand |
| issue_tag | input | TAG_W | Destination tag |
| busy | output | 1 | Operation in flight or awaiting grant |
| op_err | output | 1 | Illegal MUL dispatch to ADD-only unit |
| bus_req | output | 1 | Result bus request |
| bus_res | output | WIDTH | Held result |
| bus_tag | output | TAG_W | Held destination tag |
| bus_gnt | input | 1 | Result bus grant |

## Verification
The bench builds two instances at WIDTH = 8 and TAG_W = 3. The first keeps HAS_MUL = 1; the second sets HAS_MUL = 0. The 8-bit width makes ADD wrap-around and MUL truncation easy to reach with random operands, and it makes zero operands common enough to exercise the short MUL path under both settings of the early-completion input. The ADD-only instance gives the refused-MUL path and its error pulse, next to normal ADD completion in the same unit.

// File: rtl/fu_addmul.sv
module fu_addmul #(
  parameter int WIDTH        = 16,
  parameter int TAG_W        = 3,
  parameter bit HAS_MUL      = 1'b1,
  parameter int ADD_LAT      = 6,
  parameter int MUL_LAT      = 14,
  parameter int MUL_FAST_LAT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             early_en,
  input  logic             issue_vld,
  input  logic             issue_op,
  input  logic [WIDTH-1:0] issue_a,
  input  logic [WIDTH-1:0] issue_b,
  input  logic [TAG_W-1:0] issue_tag,
  output logic             busy,
  output logic             op_err,
  output logic             bus_req,
  output logic [WIDTH-1:0] bus_res,
  output logic [TAG_W-1:0] bus_tag,
  input  logic             bus_gnt
);
  localparam int CW = $clog2(MUL_LAT + 1);

  logic [CW-1:0]    cnt;
  logic             busy_q, done_q, err_q;
  logic [WIDTH-1:0] res_q, prod, sum;
  logic [TAG_W-1:0] tag_q;
  logic [CW-1:0]    lat;

  wire zero_op = (issue_a == '0) || (issue_b == '0);
  wire legal   = !issue_op || HAS_MUL;
  wire take    = issue_vld && !busy_q && legal;

  assign sum = issue_a + issue_b;

  generate
    if (HAS_MUL) begin : g_mul
      assign prod = zero_op ? '0 : issue_a * issue_b;
    end else begin : g_nomul
      assign prod = '0;
    end
  endgenerate

  always_comb begin
    if (!issue_op)                 lat = CW'(ADD_LAT - 1);
    else if (early_en && zero_op)  lat = CW'(MUL_FAST_LAT - 1);
    else                           lat = CW'(MUL_LAT - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      cnt    <= '0;
      res_q  <= '0;
      tag_q  <= '0;
    end else begin
      err_q <= issue_vld && !busy_q && !legal;
      if (take) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        cnt    <= lat;
        res_q  <= issue_op ? prod : sum;
        tag_q  <= issue_tag;
      end else if (busy_q && !done_q) begin
        if (cnt == '0) done_q <= 1'b1;
        else           cnt    <= cnt - 1'b1;
      end else if (done_q && bus_gnt) begin
        busy_q <= 1'b0;
        done_q <= 1'b0;
      end
    end
  end

  assign busy    = busy_q;
  assign bus_req = done_q;
  assign bus_res = res_q;
  assign bus_tag = tag_q;
  assign op_err  = err_q;
endmodule

// File: rtl/fu_addmul_chk.sv
module fu_addmul_chk #(
  parameter int WIDTH   = 16,
  parameter int TAG_W   = 3,
  parameter bit HAS_MUL = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_vld,
  input logic             issue_op,
  input logic             busy,
  input logic             op_err,
  input logic             bus_req,
  input logic [WIDTH-1:0] bus_res,
  input logic [TAG_W-1:0] bus_tag,
  input logic             bus_gnt
);
  assert_req_implies_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> busy);

  assert_accept_sets_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && !busy && (!issue_op || HAS_MUL)) |=> busy);

  assert_hold_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> (bus_req && $stable(bus_res) && $stable(bus_tag)));

  assert_grant_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt) |=> (!busy && !bus_req));

  assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_vld && issue_op && !busy && !HAS_MUL) |=> (op_err && !busy));

  assert_err_only_mulless_R9: assert property (@(posedge clk) disable iff (!rst_n)
    op_err |-> !busy);
endmodule

bind fu_addmul fu_addmul_chk #(.WIDTH(WIDTH), .TAG_W(TAG_W), .HAS_MUL(HAS_MUL)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_op(issue_op),
  .busy(busy), .op_err(op_err), .bus_req(bus_req), .bus_res(bus_res),
  .bus_tag(bus_tag), .bus_gnt(bus_gnt)
);

// File: tb/fu_addmul_tb.sv
`timescale 1ns/1ps
module fu_addmul_tb;
  localparam int W = 8;
  localparam int T = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic early_en = 1'b1;
  logic vld_f = 1'b0, vld_a = 1'b0;
  logic op = 1'b0;
  logic [W-1:0] a = '0, b = '0;
  logic [T-1:0] tag = '0;
  logic gnt_f = 1'b0, gnt_a = 1'b0;
  logic busy_f, err_f, req_f, busy_a, err_a, req_a;
  logic [W-1:0] res_f, res_a;
  logic [T-1:0] tag_f, tag_a;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fu_addmul #(.WIDTH(W), .TAG_W(T), .HAS_MUL(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .early_en(early_en), .issue_vld(vld_f),
    .issue_op(op), .issue_a(a), .issue_b(b), .issue_tag(tag),
    .busy(busy_f), .op_err(err_f), .bus_req(req_f), .bus_res(res_f),
    .bus_tag(tag_f), .bus_gnt(gnt_f));

  fu_addmul #(.WIDTH(W), .TAG_W(T), .HAS_MUL(1'b0)) u_add (
    .clk(clk), .rst_n(rst_n), .early_en(early_en), .issue_vld(vld_a),
    .issue_op(op), .issue_a(a), .issue_b(b), .issue_tag(tag),
    .busy(busy_a), .op_err(err_a), .bus_req(req_a), .bus_res(res_a),
    .bus_tag(tag_a), .bus_gnt(gnt_a));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input bit o, input logic [W-1:0] x, input logic [W-1:0] y, input bit en);
    if (!o) return 6;
    if (en && (x == 0 || y == 0)) return 5;
    return 14;
  endfunction

  function automatic logic [W-1:0] exp_res(input bit o, input logic [W-1:0] x, input logic [W-1:0] y);
    logic [2*W-1:0] p;
    if (!o) return x + y;
    p = x * y;
    return p[W-1:0];
  endfunction

  function automatic string lat_req(input bit o, input logic [W-1:0] x, input logic [W-1:0] y, input bit en);
    if (!o) return "R2";
    if (x != 0 && y != 0) return "R3";
    return en ? "R4" : "R5";
  endfunction

  task automatic run_f(input bit o, input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic [T-1:0] tg, input bit en, input bit spoil, input int hold);
    int lat;
    string rq;
    logic [W-1:0] er;
    rq = lat_req(o, x, y, en);
    er = exp_res(o, x, y);
    op = o; a = x; b = y; tag = tg; early_en = en; vld_f = 1'b1;
    @(posedge clk); @(negedge clk);
    vld_f = 1'b0;
    early_en = ~en;
    chk(busy_f === 1'b1, "R6", busy_f, 1);
    lat = 0;
    while (!req_f && lat < 40) begin
      if (spoil && lat == 1) begin
        op = ~o; a = x ^ 8'h5A; b = y + 8'd3; tag = tg + 3'd1; vld_f = 1'b1;
      end else vld_f = 1'b0;
      @(posedge clk); lat++; @(negedge clk);
    end
    vld_f = 1'b0;
    chk(lat == exp_lat(o, x, y, en), rq, lat, exp_lat(o, x, y, en));
    chk(res_f === er, spoil ? "R6" : rq, res_f, er);
    chk(tag_f === tg, "R2", tag_f, tg);
    for (int i = 0; i < hold; i++) begin
      @(posedge clk); @(negedge clk);
      chk(req_f === 1'b1 && res_f === er && tag_f === tg, "R7", res_f, er);
    end
    gnt_f = 1'b1;
    @(posedge clk); @(negedge clk);
    gnt_f = 1'b0;
    chk(busy_f === 1'b0 && req_f === 1'b0, "R8", busy_f, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(busy_f === 0 && req_f === 0 && err_f === 0, "R1", busy_f, 0);
    chk(busy_a === 0 && req_a === 0 && err_a === 0, "R1", busy_a, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_f(1'b0, 8'd200, 8'd100, 3'd5, 1'b1, 1'b0, 0);
    run_f(1'b1, 8'd17, 8'd19, 3'd2, 1'b1, 1'b0, 2);
    run_f(1'b1, 8'd0, 8'd77, 3'd1, 1'b1, 1'b0, 0);
    run_f(1'b1, 8'd91, 8'd0, 3'd6, 1'b1, 1'b1, 1);
    run_f(1'b1, 8'd0, 8'd33, 3'd3, 1'b0, 1'b0, 0);
    run_f(1'b1, 8'd255, 8'd255, 3'd7, 1'b0, 1'b1, 3);
    run_f(1'b0, 8'd0, 8'd0, 3'd0, 1'b0, 1'b1, 0);

    void'($urandom(32'd1234));
    for (int n = 0; n < 60; n++) begin
      logic [W-1:0] x, y;
      x = ($urandom % 4 == 0) ? 8'd0 : 8'($urandom);
      y = ($urandom % 4 == 0) ? 8'd0 : 8'($urandom);
      run_f(1'($urandom), x, y, 3'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 4));
    end

    op = 1'b1; a = 8'd4; b = 8'd5; tag = 3'd2; vld_a = 1'b1;
    @(posedge clk); @(negedge clk);
    vld_a = 1'b0;
    chk(err_a === 1'b1, "R9", err_a, 1);
    chk(busy_a === 1'b0, "R9", busy_a, 0);
    @(posedge clk); @(negedge clk);
    chk(err_a === 1'b0 && req_a === 1'b0, "R9", err_a, 0);

    op = 1'b0; a = 8'd250; b = 8'd9; tag = 3'd4; vld_a = 1'b1;
    @(posedge clk); @(negedge clk);
    vld_a = 1'b0;
    chk(err_a === 1'b0 && busy_a === 1'b1, "R9", busy_a, 1);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(req_a === 1'b0, "R9", req_a, 0);
    @(posedge clk); @(negedge clk);
    chk(req_a === 1'b1 && res_a === 8'd3 && tag_a === 3'd4, "R9", res_a, 3);
    gnt_a = 1'b1;
    @(posedge clk); @(negedge clk);
    gnt_a = 1'b0;
    chk(busy_a === 1'b0, "R8", busy_a, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule